// File: doc/BRIEF.md
# Beacon TBTT and DTIM Timer

This block keeps the next target beacon transmission time (TBTT), counted in time units (TU) of 1024 microseconds, against a free-running 64-bit timestamp counter that advances once per microsecond strobe. Software programs it with one arm strobe. The arm strobe carries the first TBTT, the beacon interval, the DTIM and CFP periods and phases, and a miss threshold. It also carries an enable, a station-mode flag, a staggered-slot flag and a request to zero the timestamp counter.

After arming, the block settles its schedule. A zero first TBTT becomes one interval. Any other value is rounded up to an interval multiple. If the result already lies in the past, it is stepped forward one interval at a time until it leads the current TU by a margin, and the DTIM and CFP phases advance with each step. While running, it raises one-clock pulses for each TBTT, for a software beacon alert a fixed lead before each TBTT, and for each DTIM beacon. In station mode it raises a beacon-miss interrupt after a clamped number of consecutive TBTTs that pass with no received-beacon strobe.

Top module: `bcn_tbtt_timer`

## Requirements
- R1: `tsf_o` increments by one on every clock with `tsf_tick_i` high. An arm with `reset_tsf_i` high sets it to 0 instead. `tu_o` equals `tsf_o` shifted right by 10 bits.
- R2: On arm, a zero first TBTT becomes the effective interval. A non-zero value is rounded up to a multiple of the interval. An interval of 0 leaves the value unchanged and produces no pulses.
- R3: After rounding, while next TBTT < `tu_o` + 2, the interval is added once per clock and the DTIM/CFP phases step each time. Stepping stops at the first value not below `tu_o` + 2.
- R4: A phase step works as follows. A DTIM count of 0 reloads to period − 1 and steps the CFP count, which also reloads to period − 1 from 0. Any other DTIM count decrements. A period of 0 is taken as 1, and a programmed count not below its period is taken as 0.
- R5: `next_dtim_o` = `next_tbtt_o` + `dtim_count_o` × interval, and `dtim_period_tu_o` = DTIM period × interval, both using the effective interval and the sanitised period.
- R6: With `stagger_i` high at arm, the effective interval is `interval_i` divided by SLOT_CNT (default 4).
- R7: While running, `tbtt_pulse_o` rises one clock after `tu_o` reaches `next_tbtt_o`. In the same edge `next_tbtt_o` advances by the interval.
- R8: `swba_pulse_o` rises once per beacon period, one clock after `tu_o` + ALERT_LEAD (default 1) reaches `next_tbtt_o`, and never together with `tbtt_pulse_o`.
- R9: `dtim_pulse_o` accompanies the `tbtt_pulse_o` of a beacon whose DTIM count is 0.
- R10: The miss threshold is clamped to 1..10. With `sta_mode_i` high at arm, `bmiss_irq_o` pulses together with the TBTT pulse that completes that many consecutive TBTTs without a received beacon. With `sta_mode_i` low it never pulses.
- R11: A `beacon_rx_i` strobe between two TBTTs, or in the clock of the later one, zeroes the consecutive-miss count.
- R12: An arm with `enable_i` low stops all TBTT, alert, DTIM and miss pulses.
- R13: Every pulse output is one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tsf_tick_i | input | 1 | One-microsecond advance strobe for the timestamp counter |
| arm_i | input | 1 | Loads the programming inputs and restarts the schedule |
| enable_i | input | 1 | Timer runs after arm when high |
| sta_mode_i | input | 1 | Enables beacon-miss detection |
| stagger_i | input | 1 | Splits the interval across SLOT_CNT slots |
| reset_tsf_i | input | 1 | Zeroes the timestamp counter on arm |
| next_tbtt_i | input | 32 | First TBTT in TU |
| interval_i | input | 16 | Beacon interval in TU |
| dtim_period_i | input | 8 | DTIM period in beacons |
| dtim_count_i | input | 8 | Beacons until the next DTIM |
| cfp_period_i | input | 8 | CFP period in DTIMs |
| cfp_count_i | input | 8 | DTIMs until the next CFP |
| miss_thresh_i | input | 4 | Consecutive-miss threshold before clamping |
| beacon_rx_i | input | 1 | A beacon was received |
| tsf_o | output | 64 | Timestamp counter in microseconds |
| tu_o | output | 32 | Current time in TU |
| next_tbtt_o | output | 32 | Next TBTT in TU |
| next_dtim_o | output | 32 | Next DTIM time in TU |
| dtim_period_tu_o | output | 32 | DTIM period in TU |
| dtim_count_o | output | 8 | Current DTIM countdown |
| cfp_count_o | output | 8 | Current CFP countdown |
| tbtt_pulse_o | output | 1 | TBTT pulse |
| swba_pulse_o | output | 1 | Software beacon alert pulse |
| dtim_pulse_o | output | 1 | DTIM beacon pulse |
| bmiss_irq_o | output | 1 | Beacon-miss interrupt pulse |

## Verification
The TBTT, alert, DTIM and miss pulses are all registered one clock after the TU count crosses its target. The bench therefore checks each of them by reading `tsf_o` in the cycle where the pulse is seen: 1 plus the exact microsecond of the crossing. Settling after an arm takes one rounding clock plus one clock per catch-up step. For the schedule vectors, the timestamp counter is frozen and the outputs are read 40 cycles after the arm, well past the few steps any vector needs. All sampling is at the falling edge, and inputs change only there.

// File: rtl/bt_timer_pkg.sv
package bt_timer_pkg;

    parameter int unsigned BT_TSF_W    = 64;
    parameter int unsigned BT_TU_SHIFT = 10;
    parameter int unsigned BT_TU_W     = 32;
    parameter int unsigned BT_IVAL_W   = 16;
    parameter int unsigned BT_CNT_W    = 8;
    parameter int unsigned BT_THR_W    = 4;
    parameter int unsigned BT_THR_MIN  = 1;
    parameter int unsigned BT_THR_MAX  = 10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_CATCH = 2'd2,
        ST_RUN   = 2'd3
    } bt_state_e;

    typedef struct packed {
        logic                 enable;
        logic                 stagger;
        logic [BT_TU_W-1:0]   next_tbtt;
        logic [BT_IVAL_W-1:0] interval;
        logic [BT_CNT_W-1:0]  dtim_period;
        logic [BT_CNT_W-1:0]  dtim_count;
        logic [BT_CNT_W-1:0]  cfp_period;
        logic [BT_CNT_W-1:0]  cfp_count;
    } bt_sched_cfg_t;

    typedef struct packed {
        logic [BT_CNT_W-1:0] dtim;
        logic [BT_CNT_W-1:0] cfp;
    } bt_phase_t;

    function automatic logic [BT_CNT_W-1:0] bt_fix_period(input logic [BT_CNT_W-1:0] p);
        return (p == '0) ? BT_CNT_W'(1) : p;
    endfunction

    function automatic logic [BT_CNT_W-1:0] bt_fix_count(input logic [BT_CNT_W-1:0] c,
                                                         input logic [BT_CNT_W-1:0] p);
        return (c >= p) ? '0 : c;
    endfunction

    function automatic logic [BT_THR_W-1:0] bt_clamp_thr(input logic [BT_THR_W-1:0] t);
        if (t < BT_THR_W'(BT_THR_MIN)) return BT_THR_W'(BT_THR_MIN);
        if (t > BT_THR_W'(BT_THR_MAX)) return BT_THR_W'(BT_THR_MAX);
        return t;
    endfunction

    function automatic bt_phase_t bt_step(input bt_phase_t ph,
                                          input logic [BT_CNT_W-1:0] dper,
                                          input logic [BT_CNT_W-1:0] cper);
        bt_phase_t r;
        r = ph;
        if (ph.dtim == '0) begin
            r.dtim = dper - BT_CNT_W'(1);
            r.cfp  = (ph.cfp == '0) ? (cper - BT_CNT_W'(1)) : (ph.cfp - BT_CNT_W'(1));
        end else begin
            r.dtim = ph.dtim - BT_CNT_W'(1);
        end
        return r;
    endfunction

    function automatic logic [BT_TU_W-1:0] bt_first_tbtt(input logic [BT_TU_W-1:0] t,
                                                         input logic [BT_TU_W-1:0] iv);
        logic [BT_TU_W-1:0] rem;
        if (t == '0) return iv;
        if (iv == '0) return t;
        rem = t % iv;
        return (rem == '0) ? t : (t + (iv - rem));
    endfunction

endpackage

// File: rtl/bt_tsf_counter.sv
module bt_tsf_counter
    import bt_timer_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                clear_i,
    output logic [BT_TSF_W-1:0] tsf_o,
    output logic [BT_TU_W-1:0]  tu_o
);

    logic [BT_TSF_W-1:0] tsf_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            tsf_q <= '0;
        end else if (tick_i) begin
            tsf_q <= tsf_q + BT_TSF_W'(1);
        end
    end

    assign tsf_o = tsf_q;
    assign tu_o  = tsf_q[BT_TU_SHIFT +: BT_TU_W];

endmodule

// File: rtl/bt_tbtt_sched.sv
module bt_tbtt_sched
    import bt_timer_pkg::*;
#(
    parameter int unsigned SLOT_CNT    = 4,
    parameter int unsigned ALERT_LEAD  = 1,
    parameter int unsigned CATCH_FUDGE = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 arm_i,
    input  bt_sched_cfg_t        cfg_i,
    input  logic [BT_TU_W-1:0]   tu_i,
    output logic [BT_TU_W-1:0]   next_tbtt_o,
    output logic [BT_IVAL_W-1:0] ival_o,
    output logic [BT_CNT_W-1:0]  dtim_period_o,
    output bt_phase_t            phase_o,
    output logic                 tbtt_evt_o,
    output logic                 tbtt_pulse_o,
    output logic                 swba_pulse_o,
    output logic                 dtim_pulse_o
);

    localparam logic [BT_TU_W:0] FUDGE_X = (BT_TU_W+1)'(CATCH_FUDGE);
    localparam logic [BT_TU_W:0] LEAD_X  = (BT_TU_W+1)'(ALERT_LEAD);

    bt_state_e            state_q;
    logic [BT_TU_W-1:0]   next_q;
    logic [BT_IVAL_W-1:0] ival_q;
    logic [BT_CNT_W-1:0]  dper_q;
    logic [BT_CNT_W-1:0]  cper_q;
    bt_phase_t            phase_q;
    logic                 swba_done_q;
    logic                 tbtt_q;
    logic                 swba_q;
    logic                 dtim_q;

    logic [BT_IVAL_W-1:0] split_ival;
    logic [BT_CNT_W-1:0]  dper_fix;
    logic [BT_CNT_W-1:0]  cper_fix;
    bt_phase_t            phase_init;
    bt_phase_t            phase_next;
    logic [BT_TU_W-1:0]   ival_tu;
    logic [BT_TU_W:0]     tu_x;
    logic [BT_TU_W:0]     next_x;
    logic                 stale;
    logic                 live;
    logic                 alert;

    generate
        if (SLOT_CNT > 1) begin : g_split
            assign split_ival = cfg_i.stagger ? (cfg_i.interval / BT_IVAL_W'(SLOT_CNT))
                                              : cfg_i.interval;
        end else begin : g_nosplit
            assign split_ival = cfg_i.interval;
        end
    endgenerate

    always_comb begin
        dper_fix        = bt_fix_period(cfg_i.dtim_period);
        cper_fix        = bt_fix_period(cfg_i.cfp_period);
        phase_init.dtim = bt_fix_count(cfg_i.dtim_count, dper_fix);
        phase_init.cfp  = bt_fix_count(cfg_i.cfp_count, cper_fix);
        phase_next      = bt_step(phase_q, dper_q, cper_q);
        ival_tu         = BT_TU_W'(ival_q);
        tu_x            = {1'b0, tu_i};
        next_x          = {1'b0, next_q};
        stale           = next_x < (tu_x + FUDGE_X);
        live            = (state_q == ST_RUN) && (ival_q != '0);
        tbtt_evt_o      = live && (tu_x >= next_x);
        alert           = live && !swba_done_q && ((tu_x + LEAD_X) >= next_x);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            next_q      <= '0;
            ival_q      <= '0;
            dper_q      <= BT_CNT_W'(1);
            cper_q      <= BT_CNT_W'(1);
            phase_q     <= '0;
            swba_done_q <= 1'b0;
            tbtt_q      <= 1'b0;
            swba_q      <= 1'b0;
            dtim_q      <= 1'b0;
        end else begin
            tbtt_q <= 1'b0;
            swba_q <= 1'b0;
            dtim_q <= 1'b0;
            if (arm_i) begin
                swba_done_q <= 1'b0;
                if (cfg_i.enable) begin
                    state_q <= ST_LOAD;
                    next_q  <= cfg_i.next_tbtt;
                    ival_q  <= split_ival;
                    dper_q  <= dper_fix;
                    cper_q  <= cper_fix;
                    phase_q <= phase_init;
                end else begin
                    state_q <= ST_IDLE;
                end
            end else begin
                case (state_q)
                    ST_LOAD: begin
                        next_q  <= bt_first_tbtt(next_q, ival_tu);
                        state_q <= (ival_q == '0) ? ST_RUN : ST_CATCH;
                    end
                    ST_CATCH: begin
                        if (stale) begin
                            next_q  <= next_q + ival_tu;
                            phase_q <= phase_next;
                        end else begin
                            state_q <= ST_RUN;
                        end
                    end
                    ST_RUN: begin
                        if (tbtt_evt_o) begin
                            tbtt_q      <= 1'b1;
                            dtim_q      <= (phase_q.dtim == '0);
                            phase_q     <= phase_next;
                            next_q      <= next_q + ival_tu;
                            swba_done_q <= 1'b0;
                        end else if (alert) begin
                            swba_q      <= 1'b1;
                            swba_done_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign next_tbtt_o   = next_q;
    assign ival_o        = ival_q;
    assign dtim_period_o = dper_q;
    assign phase_o       = phase_q;
    assign tbtt_pulse_o  = tbtt_q;
    assign swba_pulse_o  = swba_q;
    assign dtim_pulse_o  = dtim_q;

endmodule

// File: rtl/bt_miss_monitor.sv
module bt_miss_monitor
    import bt_timer_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                arm_i,
    input  logic                sta_mode_i,
    input  logic [BT_THR_W-1:0] thresh_i,
    input  logic                tbtt_evt_i,
    input  logic                beacon_i,
    output logic                bmiss_o
);

    logic [BT_THR_W-1:0] thr_q;
    logic [BT_THR_W-1:0] miss_q;
    logic                sta_q;
    logic                seen_q;
    logic                irq_q;
    logic                seen_now;
    logic [BT_THR_W-1:0] miss_inc;

    always_comb begin
        seen_now = seen_q || beacon_i;
        miss_inc = miss_q + BT_THR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q  <= BT_THR_W'(BT_THR_MIN);
            miss_q <= '0;
            sta_q  <= 1'b0;
            seen_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (arm_i) begin
                thr_q  <= bt_clamp_thr(thresh_i);
                sta_q  <= sta_mode_i;
                miss_q <= '0;
                seen_q <= 1'b0;
            end else if (tbtt_evt_i) begin
                seen_q <= 1'b0;
                if (seen_now) begin
                    miss_q <= '0;
                end else if (miss_q < thr_q) begin
                    miss_q <= miss_inc;
                    irq_q  <= sta_q && (miss_inc == thr_q);
                end
            end else begin
                seen_q <= seen_now;
            end
        end
    end

    assign bmiss_o = irq_q;

endmodule

// File: rtl/bcn_tbtt_timer.sv
module bcn_tbtt_timer
    import bt_timer_pkg::*;
#(
    parameter int unsigned SLOT_CNT    = 4,
    parameter int unsigned ALERT_LEAD  = 1,
    parameter int unsigned CATCH_FUDGE = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tsf_tick_i,
    input  logic                 arm_i,
    input  logic                 enable_i,
    input  logic                 sta_mode_i,
    input  logic                 stagger_i,
    input  logic                 reset_tsf_i,
    input  logic [BT_TU_W-1:0]   next_tbtt_i,
    input  logic [BT_IVAL_W-1:0] interval_i,
    input  logic [BT_CNT_W-1:0]  dtim_period_i,
    input  logic [BT_CNT_W-1:0]  dtim_count_i,
    input  logic [BT_CNT_W-1:0]  cfp_period_i,
    input  logic [BT_CNT_W-1:0]  cfp_count_i,
    input  logic [BT_THR_W-1:0]  miss_thresh_i,
    input  logic                 beacon_rx_i,
    output logic [BT_TSF_W-1:0]  tsf_o,
    output logic [BT_TU_W-1:0]   tu_o,
    output logic [BT_TU_W-1:0]   next_tbtt_o,
    output logic [BT_TU_W-1:0]   next_dtim_o,
    output logic [BT_TU_W-1:0]   dtim_period_tu_o,
    output logic [BT_CNT_W-1:0]  dtim_count_o,
    output logic [BT_CNT_W-1:0]  cfp_count_o,
    output logic                 tbtt_pulse_o,
    output logic                 swba_pulse_o,
    output logic                 dtim_pulse_o,
    output logic                 bmiss_irq_o
);

    bt_sched_cfg_t        sched_cfg;
    bt_phase_t            phase;
    logic [BT_IVAL_W-1:0] ival_eff;
    logic [BT_CNT_W-1:0]  dper_eff;
    logic                 tbtt_evt;

    always_comb begin
        sched_cfg.enable      = enable_i;
        sched_cfg.stagger     = stagger_i;
        sched_cfg.next_tbtt   = next_tbtt_i;
        sched_cfg.interval    = interval_i;
        sched_cfg.dtim_period = dtim_period_i;
        sched_cfg.dtim_count  = dtim_count_i;
        sched_cfg.cfp_period  = cfp_period_i;
        sched_cfg.cfp_count   = cfp_count_i;
    end

    bt_tsf_counter u_tsf (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tsf_tick_i),
        .clear_i (arm_i && reset_tsf_i),
        .tsf_o   (tsf_o),
        .tu_o    (tu_o)
    );

    bt_tbtt_sched #(
        .SLOT_CNT    (SLOT_CNT),
        .ALERT_LEAD  (ALERT_LEAD),
        .CATCH_FUDGE (CATCH_FUDGE)
    ) u_sched (
        .clk           (clk),
        .rst           (rst),
        .arm_i         (arm_i),
        .cfg_i         (sched_cfg),
        .tu_i          (tu_o),
        .next_tbtt_o   (next_tbtt_o),
        .ival_o        (ival_eff),
        .dtim_period_o (dper_eff),
        .phase_o       (phase),
        .tbtt_evt_o    (tbtt_evt),
        .tbtt_pulse_o  (tbtt_pulse_o),
        .swba_pulse_o  (swba_pulse_o),
        .dtim_pulse_o  (dtim_pulse_o)
    );

    bt_miss_monitor u_miss (
        .clk        (clk),
        .rst        (rst),
        .arm_i      (arm_i),
        .sta_mode_i (sta_mode_i),
        .thresh_i   (miss_thresh_i),
        .tbtt_evt_i (tbtt_evt),
        .beacon_i   (beacon_rx_i),
        .bmiss_o    (bmiss_irq_o)
    );

    always_comb begin
        dtim_count_o     = phase.dtim;
        cfp_count_o      = phase.cfp;
        next_dtim_o      = next_tbtt_o + (BT_TU_W'(phase.dtim) * BT_TU_W'(ival_eff));
        dtim_period_tu_o = BT_TU_W'(dper_eff) * BT_TU_W'(ival_eff);
    end

endmodule

// File: rtl/bt_timer_checker.sv
module bt_timer_checker
    import bt_timer_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                tsf_tick_i,
    input logic                arm_i,
    input logic                reset_tsf_i,
    input logic [BT_TSF_W-1:0] tsf_o,
    input logic [BT_TU_W-1:0]  next_tbtt_o,
    input logic                tbtt_pulse_o,
    input logic                swba_pulse_o,
    input logic                dtim_pulse_o,
    input logic                bmiss_irq_o
);

    AST_TSF_COUNT: assert property (@(posedge clk) disable iff (rst)
        (tsf_tick_i && !arm_i) |=> (tsf_o == $past(tsf_o) + BT_TSF_W'(1))); // R1

    AST_TSF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (arm_i && reset_tsf_i) |=> (tsf_o == '0)); // R1

    AST_TBTT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        tbtt_pulse_o |-> (next_tbtt_o != $past(next_tbtt_o))); // R7

    AST_SWBA_APART: assert property (@(posedge clk) disable iff (rst)
        swba_pulse_o |-> !tbtt_pulse_o); // R8

    AST_DTIM_ON_TBTT: assert property (@(posedge clk) disable iff (rst)
        dtim_pulse_o |-> tbtt_pulse_o); // R9

    AST_MISS_ON_TBTT: assert property (@(posedge clk) disable iff (rst)
        bmiss_irq_o |-> tbtt_pulse_o); // R10

    AST_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (tbtt_pulse_o || swba_pulse_o) |=> !(tbtt_pulse_o || swba_pulse_o)); // R13

endmodule

bind bcn_tbtt_timer bt_timer_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .tsf_tick_i   (tsf_tick_i),
    .arm_i        (arm_i),
    .reset_tsf_i  (reset_tsf_i),
    .tsf_o        (tsf_o),
    .next_tbtt_o  (next_tbtt_o),
    .tbtt_pulse_o (tbtt_pulse_o),
    .swba_pulse_o (swba_pulse_o),
    .dtim_pulse_o (dtim_pulse_o),
    .bmiss_irq_o  (bmiss_irq_o)
);

// File: tb/sim_bcn_tbtt_timer.sv
module sim_bcn_tbtt_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        arm = 1'b0;
    logic        en = 1'b0;
    logic        sta = 1'b0;
    logic        stag = 1'b0;
    logic        rtsf = 1'b0;
    logic [31:0] ntbtt = '0;
    logic [15:0] ival = '0;
    logic [7:0]  dper = '0;
    logic [7:0]  dcnt = '0;
    logic [7:0]  cper = '0;
    logic [7:0]  ccnt = '0;
    logic [3:0]  thr = '0;
    logic        brx = 1'b0;

    logic [63:0] tsf;
    logic [31:0] tu;
    logic [31:0] nxt;
    logic [31:0] ndtim;
    logic [31:0] dptu;
    logic [7:0]  dc;
    logic [7:0]  cc;
    logic        p_tbtt;
    logic        p_swba;
    logic        p_dtim;
    logic        p_miss;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    bcn_tbtt_timer u0 (
        .clk(clk), .rst(rst), .tsf_tick_i(tick), .arm_i(arm), .enable_i(en),
        .sta_mode_i(sta), .stagger_i(stag), .reset_tsf_i(rtsf),
        .next_tbtt_i(ntbtt), .interval_i(ival), .dtim_period_i(dper),
        .dtim_count_i(dcnt), .cfp_period_i(cper), .cfp_count_i(ccnt),
        .miss_thresh_i(thr), .beacon_rx_i(brx),
        .tsf_o(tsf), .tu_o(tu), .next_tbtt_o(nxt), .next_dtim_o(ndtim),
        .dtim_period_tu_o(dptu), .dtim_count_o(dc), .cfp_count_o(cc),
        .tbtt_pulse_o(p_tbtt), .swba_pulse_o(p_swba), .dtim_pulse_o(p_dtim),
        .bmiss_irq_o(p_miss)
    );

    typedef struct packed {
        logic [31:0] adv;
        logic [31:0] ntbtt;
        logic [15:0] ival;
        logic        stag;
        logic [7:0]  dper;
        logic [7:0]  dcnt;
        logic [7:0]  cper;
        logic [7:0]  ccnt;
        logic [31:0] e_next;
        logic [7:0]  e_dc;
        logic [7:0]  e_cc;
        logic [31:0] e_ndtim;
        logic [31:0] e_dptu;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'd0,     32'd0,   16'd100, 1'b0, 8'd3, 8'd1, 8'd1, 8'd0, 32'd100, 8'd1, 8'd0, 32'd200, 32'd300},
        '{32'd0,     32'd250, 16'd100, 1'b0, 8'd0, 8'd5, 8'd1, 8'd0, 32'd300, 8'd0, 8'd0, 32'd300, 32'd100},
        '{32'd10240, 32'd3,   16'd4,   1'b0, 8'd3, 8'd1, 8'd2, 8'd1, 32'd12,  8'd2, 8'd0, 32'd20,  32'd12},
        '{32'd0,     32'd0,   16'd400, 1'b1, 8'd2, 8'd1, 8'd1, 8'd0, 32'd100, 8'd1, 8'd0, 32'd200, 32'd200},
        '{32'd20480, 32'd20,  16'd5,   1'b0, 8'd1, 8'd0, 8'd3, 8'd0, 32'd25,  8'd0, 8'd2, 32'd25,  32'd5},
        '{32'd0,     32'd7,   16'd0,   1'b0, 8'd2, 8'd1, 8'd1, 8'd0, 32'd7,   8'd1, 8'd0, 32'd7,   32'd0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_arm(input logic e, input logic s, input logic sg, input logic r,
                          input logic [31:0] nt, input logic [15:0] iv,
                          input logic [7:0] dp, input logic [7:0] dn,
                          input logic [7:0] cp, input logic [7:0] cn, input logic [3:0] th);
        @(negedge clk);
        en = e; sta = s; stag = sg; rtsf = r; ntbtt = nt; ival = iv;
        dper = dp; dcnt = dn; cper = cp; ccnt = cn; thr = th;
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    // Runs up to max_cyc cycles; returns TBTT index of first miss interrupt (0 if none).
    task automatic miss_run(input int max_cyc, input int rx_after, output int miss_at);
        int n_tbtt = 0;
        miss_at = 0;
        for (int i = 0; i < max_cyc && miss_at == 0; i++) begin
            @(negedge clk);
            brx = 1'b0;
            if (p_tbtt) begin
                n_tbtt++;
                if (n_tbtt == rx_after) brx = 1'b1;
            end
            if (p_miss) miss_at = n_tbtt;
        end
        brx = 1'b0;
    endtask

    initial begin
        int miss_at;
        int n_tb;
        int n_sw;
        logic [63:0] tb_tsf [3];
        logic [63:0] sw_tsf [3];
        logic        tb_dtim [3];
        logic        prev_tb;
        logic        wide;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset tsf", tsf, 64'd0);
        chk("R7 reset next_tbtt", {32'd0, nxt}, 64'd0);
        chk("R13 reset pulses", {60'd0, p_tbtt, p_swba, p_dtim, p_miss}, 64'd0);

        // Schedule vectors: TSF frozen at a known value, then arm and settle.
        for (int v = 0; v < NVEC; v++) begin
            do_arm(1'b0, 1'b0, 1'b0, 1'b1, 32'd0, 16'd0, 8'd1, 8'd0, 8'd1, 8'd0, 4'd1);
            if (VECS[v].adv != 0) begin
                tick = 1'b1;
                repeat (VECS[v].adv) @(negedge clk);
                tick = 1'b0;
            end
            chk("R1 tsf count", tsf, {32'd0, VECS[v].adv});
            chk("R1 tu shift", {32'd0, tu}, {32'd0, VECS[v].adv >> 10});
            do_arm(1'b1, 1'b0, VECS[v].stag, 1'b0, VECS[v].ntbtt, VECS[v].ival,
                   VECS[v].dper, VECS[v].dcnt, VECS[v].cper, VECS[v].ccnt, 4'd1);
            repeat (40) @(negedge clk);
            chk("R2 R3 R6 next_tbtt", {32'd0, nxt}, {32'd0, VECS[v].e_next});
            chk("R3 R4 dtim_count", {56'd0, dc}, {56'd0, VECS[v].e_dc});
            chk("R4 cfp_count", {56'd0, cc}, {56'd0, VECS[v].e_cc});
            chk("R5 next_dtim", {32'd0, ndtim}, {32'd0, VECS[v].e_ndtim});
            chk("R5 dtim_period_tu", {32'd0, dptu}, {32'd0, VECS[v].e_dptu});
        end

        // Interval 0: no pulses (R2)
        n_tb = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (p_tbtt || p_swba) n_tb++;
        end
        chk("R2 zero interval silent", n_tb, 0);

        // Pulse timing: interval 2 TU, DTIM period 2 starting at 0, station mode off.
        tick = 1'b1;
        do_arm(1'b1, 1'b0, 1'b0, 1'b1, 32'd0, 16'd2, 8'd2, 8'd0, 8'd1, 8'd0, 4'd1);
        n_tb = 0; n_sw = 0; prev_tb = 1'b0; wide = 1'b0; miss_at = 0;
        for (int i = 0; i < 7000; i++) begin
            @(negedge clk);
            if (p_tbtt && prev_tb) wide = 1'b1;
            prev_tb = p_tbtt;
            if (p_miss) miss_at = 1;
            if (p_swba && n_sw < 3) begin sw_tsf[n_sw] = tsf; n_sw++; end
            if (p_tbtt && n_tb < 3) begin
                tb_tsf[n_tb] = tsf; tb_dtim[n_tb] = p_dtim; n_tb++;
                if (n_tb == 1) begin
                    @(negedge clk);
                    prev_tb = p_tbtt;
                    if (p_tbtt) wide = 1'b1;
                    chk("R7 next advance", {32'd0, nxt}, 64'd4);
                    chk("R13 tbtt width", {63'd0, p_tbtt}, 64'd0);
                end
            end
        end
        chk("R7 tbtt count", n_tb, 3);
        chk("R8 alert count", n_sw, 3);
        chk("R7 tbtt1 time", tb_tsf[0], 64'd2049);
        chk("R7 tbtt2 time", tb_tsf[1], 64'd4097);
        chk("R7 tbtt3 time", tb_tsf[2], 64'd6145);
        chk("R8 alert1 time", sw_tsf[0], 64'd1025);
        chk("R8 alert2 time", sw_tsf[1], 64'd3073);
        chk("R8 alert3 time", sw_tsf[2], 64'd5121);
        chk("R9 dtim beacon1", {63'd0, tb_dtim[0]}, 64'd1);
        chk("R9 dtim beacon2", {63'd0, tb_dtim[1]}, 64'd0);
        chk("R9 dtim beacon3", {63'd0, tb_dtim[2]}, 64'd1);
        chk("R13 no wide pulse", {63'd0, wide}, 64'd0);
        chk("R10 no miss outside station mode", miss_at, 0);

        // Threshold 0 clamps to 1.
        do_arm(1'b1, 1'b1, 1'b0, 1'b1, 32'd0, 16'd2, 8'd1, 8'd0, 8'd1, 8'd0, 4'd0);
        miss_run(3000, 0, miss_at);
        chk("R10 clamp low", miss_at, 1);

        // Threshold 12 clamps to 10.
        do_arm(1'b1, 1'b1, 1'b0, 1'b1, 32'd0, 16'd2, 8'd1, 8'd0, 8'd1, 8'd0, 4'd12);
        miss_run(24000, 0, miss_at);
        chk("R10 clamp high", miss_at, 10);

        // Threshold 3, beacon after TBTT 2: count restarts, interrupt at TBTT 6.
        do_arm(1'b1, 1'b1, 1'b0, 1'b1, 32'd0, 16'd2, 8'd1, 8'd0, 8'd1, 8'd0, 4'd3);
        miss_run(15000, 2, miss_at);
        chk("R11 beacon resets misses", miss_at, 6);

        // Disable while running.
        do_arm(1'b0, 1'b1, 1'b0, 1'b0, 32'd0, 16'd2, 8'd1, 8'd0, 8'd1, 8'd0, 4'd1);
        n_tb = 0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (p_tbtt || p_swba || p_dtim || p_miss) n_tb++;
        end
        chk("R12 disabled silent", n_tb, 0);
        tick = 1'b0;

        finish_run();
    end

endmodule